// File: doc/BRIEF.md
# System Exception Control Register Block

This block is the memory-mapped control window that a small microcontroller core uses to configure and observe its system exceptions. A simple 32-bit word bus reaches nine word slots. They hold a fixed identification word, an exception control and status word, a reset control word guarded by a key, a sleep control word, a fixed configuration word and two priority words for the supervisor-call, deferred-service and tick exceptions.

Three exceptions have pending bits in this block: the non-maskable interrupt, the deferred service call and the tick. Software sets and clears these bits through separate write-one-to-set and write-one-to-clear positions. A hardware tick event can also set the tick bit. An acknowledge from the core's exception entry logic clears the bit for the exception being entered. The core supplies the active exception number, the highest pending vector and an interrupt-pending flag, and the block reports them in its status word. A keyed write can request a system reset, which the block gives as a single-cycle pulse. Exception arbitration itself is done elsewhere.

Reads are combinational. Writes take effect at the rising clock edge where `bus_en` and `bus_we` are both high. Only word-aligned addresses are decoded.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, all pending outputs, priority outputs, sleep controls and `reset_req` are 0. The reset control word (0x0C) reads 0xFA050000.
- R2: Offset 0x00 always reads 0x410CC200 and offset 0x14 always reads 0x00000204. Offsets 0x08 and 0x18 read 0. A write to any of these four offsets changes no output and no readback.
- R3: A write to offset 0x0C is accepted only when wdata[31:16] equals 0x05FA. Any other value discards the whole write, and `reset_req` stays low.
- R4: An accepted write to 0x0C with bit 2 set drives `reset_req` high for exactly the one cycle after the write edge. Bit 1 has no effect. Offset 0x0C always reads 0xFA050000, so bit 15 (little-endian) reads 0.
- R5: At offset 0x04, writing 1 sets a pending bit: bit 31 for the non-maskable interrupt, bit 28 for the deferred service call and bit 26 for the tick. Each pending bit reads back at the same position and appears on its pending output after the write edge.
- R6: At offset 0x04, writing 1 to bit 27 clears the deferred-service pending bit and writing 1 to bit 25 clears the tick pending bit. When set and clear are written together, clear wins. The clear bits read 0.
- R7: Offset 0x04 reports `act_exc` in bits 5:0, `pend_vec` in bits 17:12 and `irq_pending` in bit 22. These fields follow the inputs in the same cycle.
- R8: Offset 0x10 stores sleep-on-exit in bit 1, deep-sleep in bit 2 and send-event-on-pend in bit 4, and drives them to the matching outputs. All other bits read 0.
- R9: Offset 0x1C bits 31:30 hold the supervisor-call priority. Offset 0x20 bits 23:22 hold the deferred-service priority and bits 31:30 hold the tick priority. All other bits of both words read 0.
- R10: `systick_evt` sets the tick pending bit. `ack_valid` with `ack_num` 2, 14 or 15 clears the non-maskable, deferred-service or tick pending bit respectively. A clear in the same cycle beats any set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| act_exc | input | 6 | Currently active exception number |
| pend_vec | input | 6 | Highest-priority pending exception number |
| irq_pending | input | 1 | Any external interrupt pending |
| systick_evt | input | 1 | Hardware tick event |
| ack_valid | input | 1 | Exception entry acknowledge |
| ack_num | input | 6 | Exception number being entered |
| nmi_pend | output | 1 | Non-maskable interrupt pending |
| pendsv_pend | output | 1 | Deferred service call pending |
| systick_pend | output | 1 | Tick exception pending |
| svc_prio | output | 2 | Supervisor-call priority, top two bits |
| pendsv_prio | output | 2 | Deferred service priority, top two bits |
| systick_prio | output | 2 | Tick priority, top two bits |
| sleep_on_exit | output | 1 | Sleep on return from the last handler |
| deep_sleep | output | 1 | Select the deeper low-power mode |
| sev_on_pend | output | 1 | Wake event on a new pending interrupt |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest cases are collisions on the pending bits in a single cycle. A bus set can meet a bus clear, or a hardware tick event can meet an exception-entry acknowledge for the same exception. Driving these through the ports requires `systick_evt`, `ack_valid` and a bus write to offset 0x04 to be presented together in the same cycle. The bench presents them at one falling edge, holds them over exactly one rising edge, and then reads the pending output and the status word. The key guard is tested in the same way with near-miss key values that carry the reset-request bit, and a discarded write must leave `reset_req` low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int WORD_W   = 32;
    localparam int EXC_W    = 6;

    // word slot indices (byte offset / 4)
    localparam int SLOT_ID    = 0;
    localparam int SLOT_ICS   = 1;
    localparam int SLOT_RST   = 3;
    localparam int SLOT_SLP   = 4;
    localparam int SLOT_CFG   = 5;
    localparam int SLOT_PRIA  = 7;
    localparam int SLOT_PRIB  = 8;

    localparam logic [31:0] ID_WORD   = 32'h410C_C200;
    localparam logic [31:0] CFG_WORD  = 32'h0000_0204;
    localparam logic [31:0] RST_READ  = 32'hFA05_0000;
    localparam logic [15:0] RST_KEY   = 16'h05FA;

    localparam logic [EXC_W-1:0] EXC_NMI    = 6'd2;
    localparam logic [EXC_W-1:0] EXC_PENDSV = 6'd14;
    localparam logic [EXC_W-1:0] EXC_TICK   = 6'd15;

    // pending bank index order
    localparam int PND_NMI  = 0;
    localparam int PND_PSV  = 1;
    localparam int PND_TICK = 2;
    localparam int PND_N    = 3;

    typedef struct packed {
        logic       sleep_exit;
        logic       deep;
        logic       sev;
        logic [1:0] svc_pr;
        logic [1:0] psv_pr;
        logic [1:0] tick_pr;
        logic       rst_req;
    } ctl_t;
endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec #(
    parameter int ADDR_W = 6,
    localparam int NSLOT = 2 ** (ADDR_W - 2)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSLOT-1:0]  sel
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign sel[i] = en && (addr[1:0] == 2'b00) &&
                        (addr[ADDR_W-1:2] == (ADDR_W-2)'(i));
    end
endmodule

// File: rtl/sysctl_pend_bank.sv
module sysctl_pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // clear has priority over every set source
        always_comb begin
            pend_d[i] = (pend_q[i] | set_i[i]) & ~clr_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux #(
    parameter int NSLOT  = 16,
    parameter int WORD_W = 32
) (
    input  logic [NSLOT-1:0]        sel,
    input  logic [NSLOT*WORD_W-1:0] words,
    output logic [WORD_W-1:0]       rdata
);
    logic [NSLOT-1:0][WORD_W-1:0] gated;

    for (genvar i = 0; i < NSLOT; i++) begin : g_gate
        assign gated[i] = sel[i] ? words[i*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) rdata = rdata | gated[i];
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        act_exc,
    input  logic [5:0]        pend_vec,
    input  logic              irq_pending,
    input  logic              systick_evt,
    input  logic              ack_valid,
    input  logic [5:0]        ack_num,
    output logic              nmi_pend,
    output logic              pendsv_pend,
    output logic              systick_pend,
    output logic [1:0]        svc_prio,
    output logic [1:0]        pendsv_prio,
    output logic [1:0]        systick_prio,
    output logic              sleep_on_exit,
    output logic              deep_sleep,
    output logic              sev_on_pend,
    output logic              reset_req
);
    localparam int NSLOT = 2 ** (ADDR_W - 2);

    logic [NSLOT-1:0]        sel;
    logic [NSLOT*WORD_W-1:0] words;
    logic [PND_N-1:0]        pnd_set, pnd_clr, pnd_q;
    logic                    wr_ics, wr_rst, wr_slp, wr_pria, wr_prib;
    logic                    key_ok;
    logic [31:0]             ics_word;
    ctl_t                    ctl_d, ctl_q;

    sysctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .en   (bus_en),
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_ics  = sel[SLOT_ICS]  & bus_we;
    assign wr_rst  = sel[SLOT_RST]  & bus_we;
    assign wr_slp  = sel[SLOT_SLP]  & bus_we;
    assign wr_pria = sel[SLOT_PRIA] & bus_we;
    assign wr_prib = sel[SLOT_PRIB] & bus_we;
    assign key_ok  = (bus_wdata[31:16] == RST_KEY);

    // pending set/clear sources
    always_comb begin
        pnd_set[PND_NMI]  = wr_ics & bus_wdata[31];
        pnd_set[PND_PSV]  = wr_ics & bus_wdata[28];
        pnd_set[PND_TICK] = (wr_ics & bus_wdata[26]) | systick_evt;
        pnd_clr[PND_NMI]  = ack_valid & (ack_num == EXC_NMI);
        pnd_clr[PND_PSV]  = (wr_ics & bus_wdata[27]) |
                            (ack_valid & (ack_num == EXC_PENDSV));
        pnd_clr[PND_TICK] = (wr_ics & bus_wdata[25]) |
                            (ack_valid & (ack_num == EXC_TICK));
    end

    sysctl_pend_bank #(.N(PND_N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pnd_set),
        .clr_i  (pnd_clr),
        .pend_o (pnd_q)
    );

    // control state next value
    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rst_req = wr_rst & key_ok & bus_wdata[2];
        if (wr_slp) begin
            ctl_d.sleep_exit = bus_wdata[1];
            ctl_d.deep       = bus_wdata[2];
            ctl_d.sev        = bus_wdata[4];
        end
        if (wr_pria) ctl_d.svc_pr = bus_wdata[31:30];
        if (wr_prib) begin
            ctl_d.psv_pr  = bus_wdata[23:22];
            ctl_d.tick_pr = bus_wdata[31:30];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // readback words
    always_comb begin
        ics_word        = '0;
        ics_word[31]    = pnd_q[PND_NMI];
        ics_word[28]    = pnd_q[PND_PSV];
        ics_word[26]    = pnd_q[PND_TICK];
        ics_word[22]    = irq_pending;
        ics_word[17:12] = pend_vec;
        ics_word[5:0]   = act_exc;
    end

    always_comb begin
        words = '0;
        words[SLOT_ID*WORD_W   +: WORD_W] = ID_WORD;
        words[SLOT_ICS*WORD_W  +: WORD_W] = ics_word;
        words[SLOT_RST*WORD_W  +: WORD_W] = RST_READ;
        words[SLOT_SLP*WORD_W  +: WORD_W] = {27'b0, ctl_q.sev, 1'b0,
                                             ctl_q.deep, ctl_q.sleep_exit, 1'b0};
        words[SLOT_CFG*WORD_W  +: WORD_W] = CFG_WORD;
        words[SLOT_PRIA*WORD_W +: WORD_W] = {ctl_q.svc_pr, 30'b0};
        words[SLOT_PRIB*WORD_W +: WORD_W] = {ctl_q.tick_pr, 6'b0,
                                             ctl_q.psv_pr, 22'b0};
    end

    sysctl_read_mux #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_rmux (
        .sel   (sel),
        .words (words),
        .rdata (bus_rdata)
    );

    assign nmi_pend      = pnd_q[PND_NMI];
    assign pendsv_pend   = pnd_q[PND_PSV];
    assign systick_pend  = pnd_q[PND_TICK];
    assign svc_prio      = ctl_q.svc_pr;
    assign pendsv_prio   = ctl_q.psv_pr;
    assign systick_prio  = ctl_q.tick_pr;
    assign sleep_on_exit = ctl_q.sleep_exit;
    assign deep_sleep    = ctl_q.deep;
    assign sev_on_pend   = ctl_q.sev;
    assign reset_req     = ctl_q.rst_req;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              systick_evt,
    input logic              ack_valid,
    input logic [5:0]        ack_num,
    input logic              pendsv_pend,
    input logic              systick_pend,
    input logic [1:0]        svc_prio,
    input logic              reset_req
);
    logic ics_wr, rst_wr, any_wr;
    assign ics_wr = bus_en && bus_we && bus_addr == ADDR_W'(6'h04);
    assign rst_wr = bus_en && bus_we && bus_addr == ADDR_W'(6'h0C);
    assign any_wr = bus_en && bus_we;

    // R2: identification word is constant on reads
    p_id_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == '0) |-> bus_rdata == 32'h410C_C200);

    // R3: a write without the key never requests reset
    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_wr && bus_wdata[31:16] != 16'h05FA) |=> !reset_req);

    // R4: reset request only follows a keyed write with bit 2
    p_rst_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(rst_wr && bus_wdata[31:16] == 16'h05FA && bus_wdata[2]));

    // R5: a bus set alone makes the deferred service call pending
    p_psv_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ics_wr && bus_wdata[28] && !bus_wdata[27] &&
         !(ack_valid && ack_num == 6'd14)) |=> pendsv_pend);

    // R6: clear beats set in the same write
    p_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ics_wr && bus_wdata[28] && bus_wdata[27]) |=> !pendsv_pend);

    // R9: priority holds without a bus write
    p_prio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> $stable(svc_prio));

    // R10: hardware tick event sets pending unless cleared
    p_tick_hw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (systick_evt && !(ack_valid && ack_num == 6'd15) &&
         !(ics_wr && bus_wdata[25])) |=> systick_pend);
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .systick_evt  (systick_evt),
    .ack_valid    (ack_valid),
    .ack_num      (ack_num),
    .pendsv_pend  (pendsv_pend),
    .systick_pend (systick_pend),
    .svc_prio     (svc_prio),
    .reset_req    (reset_req)
);

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  act_exc = '0, pend_vec = '0, ack_num = '0;
    logic        irq_pending = 1'b0, systick_evt = 1'b0, ack_valid = 1'b0;
    logic        nmi_pend, pendsv_pend, systick_pend;
    logic [1:0]  svc_prio, pendsv_prio, systick_prio;
    logic        sleep_on_exit, deep_sleep, sev_on_pend, reset_req;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regs u_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .act_exc(act_exc), .pend_vec(pend_vec), .irq_pending(irq_pending),
        .systick_evt(systick_evt), .ack_valid(ack_valid), .ack_num(ack_num),
        .nmi_pend(nmi_pend), .pendsv_pend(pendsv_pend),
        .systick_pend(systick_pend), .svc_prio(svc_prio),
        .pendsv_prio(pendsv_prio), .systick_prio(systick_prio),
        .sleep_on_exit(sleep_on_exit), .deep_sleep(deep_sleep),
        .sev_on_pend(sev_on_pend), .reset_req(reset_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one write over exactly one rising edge; returns at falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1", "pending outputs", {29'b0, nmi_pend, pendsv_pend, systick_pend}, 32'h0);
        check("R1", "prio outputs", {26'b0, svc_prio, pendsv_prio, systick_prio}, 32'h0);
        check("R1", "sleep outputs", {28'b0, sleep_on_exit, deep_sleep, sev_on_pend, reset_req}, 32'h0);
        rd(6'h0C, d); check("R1", "reset word", d, 32'hFA05_0000);
    endtask

    task automatic t_fixed_words();
        logic [31:0] d;
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h08, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h00, d); check("R2", "id word", d, 32'h410C_C200);
        rd(6'h14, d); check("R2", "cfg word", d, 32'h0000_0204);
        rd(6'h08, d); check("R2", "reserved 08", d, 32'h0);
        rd(6'h18, d); check("R2", "reserved 18", d, 32'h0);
        check("R2", "outputs untouched",
              {20'b0, nmi_pend, pendsv_pend, systick_pend, svc_prio, pendsv_prio,
               systick_prio, sleep_on_exit, deep_sleep, sev_on_pend}, 32'h0);
    endtask

    task automatic t_reset_key();
        logic [31:0] d;
        wr(6'h0C, 32'h05FB_0004); check("R3", "bad key low", reset_req, 0);
        wr(6'h0C, 32'h85FA_0004); check("R3", "bit31 key miss", reset_req, 0);
        wr(6'h0C, 32'h0000_0004); check("R3", "no key", reset_req, 0);
        wr(6'h0C, 32'h05FA_0002); check("R4", "bit1 no effect", reset_req, 0);
        wr(6'h0C, 32'h05FA_0004); check("R4", "pulse high", reset_req, 1);
        @(negedge clk);           check("R4", "pulse ends", reset_req, 0);
        rd(6'h0C, d);             check("R4", "readback fixed", d, 32'hFA05_0000);
    endtask

    task automatic t_pend_set();
        logic [31:0] d;
        wr(6'h04, 32'h9400_0000);
        check("R5", "pending outs", {29'b0, nmi_pend, pendsv_pend, systick_pend}, 32'h7);
        rd(6'h04, d); check("R5", "status bits", d & 32'h9E00_0000, 32'h9400_0000);
    endtask

    task automatic t_pend_clr();
        logic [31:0] d;
        wr(6'h04, 32'h0A00_0000);
        check("R6", "cleared psv/tick", {30'b0, pendsv_pend, systick_pend}, 32'h0);
        check("R6", "nmi kept", nmi_pend, 1);
        wr(6'h04, 32'h1800_0000);
        check("R6", "psv clr wins", pendsv_pend, 0);
        wr(6'h04, 32'h0600_0000);
        check("R6", "tick clr wins", systick_pend, 0);
        rd(6'h04, d); check("R6", "clear bits read 0", d & 32'h0A00_0000, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        @(negedge clk);
        act_exc = 6'd11; pend_vec = 6'd45; irq_pending = 1'b1;
        rd(6'h04, d); check("R7", "status A", d & 32'h0043_F03F, 32'h0042_D00B);
        act_exc = 6'd63; pend_vec = 6'd0; irq_pending = 1'b0;
        rd(6'h04, d); check("R7", "status B", d & 32'h0043_F03F, 32'h0000_003F);
        act_exc = '0;
    endtask

    task automatic t_sleep();
        logic [31:0] d;
        wr(6'h10, 32'hFFFF_FFFF);
        check("R8", "sleep outs", {29'b0, sleep_on_exit, deep_sleep, sev_on_pend}, 32'h7);
        rd(6'h10, d); check("R8", "sleep readback", d, 32'h16);
        wr(6'h10, 32'h0000_0004);
        check("R8", "only deep", {29'b0, sleep_on_exit, deep_sleep, sev_on_pend}, 32'h2);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h20, 32'h7FFF_FFFF);
        check("R9", "svc prio", svc_prio, 2'd3);
        check("R9", "psv prio", pendsv_prio, 2'd3);
        check("R9", "tick prio", systick_prio, 2'd1);
        rd(6'h1C, d); check("R9", "pri A read", d, 32'hC000_0000);
        rd(6'h20, d); check("R9", "pri B read", d, 32'h40C0_0000);
        wr(6'h20, 32'h8040_0000);
        check("R9", "pri B second", {28'b0, pendsv_prio, systick_prio}, 32'h6);
    endtask

    task automatic t_hw_ack();
        @(negedge clk); systick_evt = 1'b1;
        @(negedge clk); systick_evt = 1'b0;
        check("R10", "hw tick sets", systick_pend, 1);
        ack_valid = 1'b1; ack_num = 6'd15;
        @(negedge clk); ack_valid = 1'b0;
        check("R10", "ack 15 clears", systick_pend, 0);
        systick_evt = 1'b1; ack_valid = 1'b1;
        @(negedge clk); systick_evt = 1'b0; ack_valid = 1'b0;
        check("R10", "ack beats hw set", systick_pend, 0);
        ack_valid = 1'b1; ack_num = 6'd2;
        @(negedge clk); ack_valid = 1'b0;
        check("R10", "ack 2 clears nmi", nmi_pend, 0);
        wr(6'h04, 32'h1000_0000);
        ack_valid = 1'b1; ack_num = 6'd14;
        @(negedge clk); ack_valid = 1'b0;
        check("R10", "ack 14 clears psv", pendsv_pend, 0);
        ack_valid = 1'b1; ack_num = 6'd15; systick_evt = 1'b1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h0400_0000;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; ack_valid = 1'b0; systick_evt = 1'b0;
        check("R10", "ack beats bus+hw set", systick_pend, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_fixed_words();
        t_reset_key();
        t_pend_set();
        t_pend_clr();
        t_status();
        t_sleep();
        t_prio();
        t_hw_ack();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule